// File: doc/BRIEF.md
# VMEbus Master Write Engine

This block lets a local processor write words onto a VMEbus as a bus master. Software first loads three configuration registers through a small write port: a control word (address modifier code, WRITE and LWORD line levels, and an 8-bit interrupt vector), the upper address half A16–A31, and an optional upper data half used for 32-bit words. A single launch strobe then carries the lower address bits A01–A15 and up to 24 data bits. That strobe starts the whole cycle: a bus request at the selected level, a wait for the grant, address and data drive, the strobes, and termination on DTACK.

The engine can also keep mastership across many transfers. An active-low hold control requests the bus ahead of a burst and keeps it between transfers. A block-transfer option keeps the address strobe asserted across beats and drives the address only on the first beat. Grant lines from upstream pass through to downstream boards on every level this block is not using.

The sequencer has seven states. **IDLE**: no request. **REQ**: bus requested, waiting for the grant. **OWN**: the bus is held with no cycle in progress. **SETUP**: address and data are driven while the strobes are still high. **STROBE**: AS and both data strobes are low, waiting for DTACK. **RECOVER**: the strobes are high, waiting for DTACK to be released. **BLT_IDLE**: inside a block, with AS held low between beats.

The transitions are:
- IDLE→REQ on a launch or on hold low.
- REQ→SETUP when the grant arrives with a launch pending; REQ→OWN when the grant arrives with no launch pending.
- OWN→SETUP on a launch; OWN→IDLE when hold goes high.
- SETUP→STROBE after one cycle.
- STROBE→RECOVER on DTACK.
- RECOVER→BLT_IDLE, →OWN or →IDLE once DTACK is released.
- BLT_IDLE→SETUP on a launch; BLT_IDLE→OWN or →IDLE when the block option drops.

Top module: `vme_master_writer`

## Requirements
- R1: After reset, `done`=1, `has_bus`=0, all `vme_br_n` lines are high, `vme_as_n`=1, `vme_ds_n`=2'b11, and every output enable is 0.
- R2: A `cfg_we` pulse stores `cfg_wdata` into the register picked by `cfg_sel`:
  - code 0: control word;
  - code 1: A16–A31 from bits 15:0;
  - code 2: upper data half from bits 15:0.
  The A16–A31 value keeps its content across any number of bus cycles until it is rewritten.
- R3: A `go` pulse while `done`=1 latches `go_addr`/`go_data`/`wide`. If the bus is not already held, the next cycle shows `vme_br_n[br_level]` low with all other request lines high, and `done`=0.
- R4: Once the synchronised grant is seen, one cycle drives address and data with the strobes high. Then AS and both DS lines go low and stay low until DTACK has been sampled low.
- R5: With `wide`=1, `vme_data` is {upper data half, `go_data[15:0]`}, and both `vme_data_oe_lo` and `vme_data_oe_hi` are 1 while data is driven.
- R6: With `wide`=0, `vme_data[23:0]` equals `go_data`, and bits 31:24 are left undriven (`vme_data_oe_hi`=0).
- R7: While the address is driven:
  - `vme_am` equals control bits 5:0;
  - `vme_write_n` equals control bit 6;
  - `vme_lword_n` equals control bit 7.
  `irq_vector` always shows control bits 23:16.
- R8: After DTACK, the strobes rise, the engine waits for DTACK to be released, and it then returns to idle. Bus request lines are never all released while AS is low. When the engine is idle, `done`=1 and `has_bus`=0.
- R9: While `hold_n`=0, the engine requests the bus with no transfer pending. `has_bus` stays 1 and the request line stays low between transfers, with AS high. Raising `hold_n` releases the request.
- R10: With `blt_en`=1, AS stays low between beats and the address is driven only on the first beat of a block. Lowering `blt_en` between beats raises AS and ends the block.
- R11: For every level other than the one being requested, `vme_bg_out_n` follows `vme_bg_in_n`. While this block requests, its own level's `vme_bg_out_n` is held high.
- R12: A `go` pulse while `done`=0 is ignored: it causes no extra bus cycle and does not change the data of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 high address, 2 upper data |
| cfg_wdata | input | 24 | Configuration write data |
| go | input | 1 | Launch strobe for one bus write |
| go_addr | input | 15 | Address bits A01–A15 of the launch |
| go_data | input | 24 | Data bits D0–D23 of the launch |
| wide | input | 1 | 1: 32-bit word, 0: 24-bit word |
| blt_en | input | 1 | Block-transfer option |
| hold_n | input | 1 | Active-low request to gain and hold the bus |
| br_level | input | 2 | Bus request level 0–3 |
| has_bus | output | 1 | Block currently owns the bus |
| done | output | 1 | Engine ready for the next launch |
| irq_vector | output | 8 | Interrupt vector from the control word |
| vme_br_n | output | 4 | Bus request lines, active low |
| vme_bg_in_n | input | 4 | Bus grant inputs from upstream, active low |
| vme_bg_out_n | output | 4 | Bus grant outputs to downstream, active low |
| vme_as_n | output | 1 | Address strobe, active low |
| vme_ds_n | output | 2 | Data strobes, active low |
| vme_dtack_n | input | 1 | Data acknowledge from slave, active low |
| vme_addr | output | 31 | Address lines A01–A31 |
| vme_am | output | 6 | Address modifier code |
| vme_write_n | output | 1 | WRITE line level |
| vme_lword_n | output | 1 | LWORD line level |
| vme_addr_oe | output | 1 | Enable for address, AM, WRITE, LWORD |
| vme_data | output | 32 | Data lines D00–D31 |
| vme_data_oe_lo | output | 1 | Enable for data bits 23:0 |
| vme_data_oe_hi | output | 1 | Enable for data bits 31:24 |

## Verification
The hardest situation to reach is a block transfer running inside a held bus. In that case AS must stay low through BLT_IDLE, later beats must leave the address undriven, and ending the block must land in OWN rather than IDLE. The bench gets there by dropping `hold_n` first, waiting for `has_bus`, and raising `blt_en` before the first launch. It then issues several launches back to back and lowers `blt_en` only while `done` shows the engine is between beats. A go pulse timed while DTACK is still pending checks that launches arriving mid-cycle are discarded.

// File: rtl/vmw_pkg.sv
package vmw_pkg;

    localparam int LO_ADDR_W = 15;
    localparam int HI_ADDR_W = 16;
    localparam int LO_DATA_W = 24;
    localparam int UP_DATA_W = 16;
    localparam int CFG_W     = 24;
    localparam int BUS_DATA_W = 32;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_HIADDR = 2'd1;
    localparam logic [1:0] SEL_UPDATA = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ,
        S_OWN,
        S_SETUP,
        S_STROBE,
        S_RECOVER,
        S_BLT_IDLE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] vector;
        logic       lword_lvl;
        logic       write_lvl;
        logic [5:0] am;
    } ctrl_t;

endpackage

// File: rtl/vmw_sync.sv
module vmw_sync #(
    parameter int   STAGES  = 2,
    parameter int   WIDTH   = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= {WIDTH{RST_VAL}};
                    else        pipe[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[g] <= {WIDTH{RST_VAL}};
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/vmw_regs.sv
module vmw_regs
    import vmw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output ctrl_t                ctrl,
    output logic [HI_ADDR_W-1:0] hi_addr,
    output logic [UP_DATA_W-1:0] up_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            hi_addr <= '0;
            up_data <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel)
                SEL_CTRL: begin
                    ctrl.am        <= cfg_wdata[5:0];
                    ctrl.write_lvl <= cfg_wdata[6];
                    ctrl.lword_lvl <= cfg_wdata[7];
                    ctrl.vector    <= cfg_wdata[23:16];
                end
                SEL_HIADDR: hi_addr <= cfg_wdata[HI_ADDR_W-1:0];
                SEL_UPDATA: up_data <= cfg_wdata[UP_DATA_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/vmw_arb.sv
module vmw_arb #(
    parameter  int LEVELS = 4,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input  logic [LVL_W-1:0]  br_level,
    input  logic              req,
    input  logic [LEVELS-1:0] bg_in_n,
    output logic [LEVELS-1:0] br_n,
    output logic [LEVELS-1:0] bg_out_n,
    output logic              bg_sel_n
);

    generate
        for (genvar i = 0; i < LEVELS; i++) begin : g_lane
            logic mine;
            assign mine        = req && (br_level == LVL_W'(i));
            assign br_n[i]     = ~mine;
            assign bg_out_n[i] = bg_in_n[i] | mine;
        end
    endgenerate

    assign bg_sel_n = bg_in_n[br_level];

endmodule

// File: rtl/vmw_seq.sv
module vmw_seq
    import vmw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic [LO_ADDR_W-1:0] go_addr,
    input  logic [LO_DATA_W-1:0] go_data,
    input  logic                 wide,
    input  logic                 blt_en,
    input  logic                 hold_n,
    input  logic                 granted,
    input  logic                 acked,
    output logic                 req,
    output logic                 has_bus,
    output logic                 done,
    output logic                 as_n,
    output logic [1:0]           ds_n,
    output logic                 addr_oe,
    output logic                 data_oe,
    output logic [LO_ADDR_W-1:0] lo_addr,
    output logic [LO_DATA_W-1:0] lo_data,
    output logic                 wide_q
);

    seq_state_t state, nxt;
    logic pend;
    logic blt_cont;
    logic accept;

    assign accept = go && done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (go || !hold_n) nxt = S_REQ;
            end
            S_REQ: begin
                if (granted) nxt = pend ? S_SETUP : S_OWN;
            end
            S_OWN: begin
                if (go)          nxt = S_SETUP;
                else if (hold_n) nxt = S_IDLE;
            end
            S_SETUP: nxt = S_STROBE;
            S_STROBE: begin
                if (acked) nxt = S_RECOVER;
            end
            S_RECOVER: begin
                if (!acked) begin
                    if (blt_cont)     nxt = S_BLT_IDLE;
                    else if (!hold_n) nxt = S_OWN;
                    else              nxt = S_IDLE;
                end
            end
            S_BLT_IDLE: begin
                if (go)           nxt = S_SETUP;
                else if (!blt_en) nxt = hold_n ? S_IDLE : S_OWN;
            end
            default: nxt = S_IDLE;
        endcase
    end

    // launch capture and block tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_addr  <= '0;
            lo_data  <= '0;
            wide_q   <= 1'b0;
            pend     <= 1'b0;
            blt_cont <= 1'b0;
        end else begin
            if (accept) begin
                lo_addr <= go_addr;
                lo_data <= go_data;
                wide_q  <= wide;
            end
            if (state == S_IDLE)     pend <= go;
            else if (state != S_REQ) pend <= 1'b0;
            if (state == S_STROBE && acked)
                blt_cont <= blt_en;
            else if (state == S_BLT_IDLE && !go && !blt_en)
                blt_cont <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        req     = (state != S_IDLE);
        done    = (state == S_IDLE) || (state == S_OWN) || (state == S_BLT_IDLE);
        has_bus = (state == S_OWN) || (state == S_SETUP) || (state == S_STROBE) ||
                  (state == S_RECOVER) || (state == S_BLT_IDLE);
        data_oe = (state == S_SETUP) || (state == S_STROBE);
        addr_oe = data_oe && !blt_cont;
        as_n    = !((state == S_STROBE) ||
                    (blt_cont && ((state == S_SETUP) || (state == S_RECOVER) ||
                                  (state == S_BLT_IDLE))));
        ds_n    = (state == S_STROBE) ? 2'b00 : 2'b11;
    end

endmodule

// File: rtl/vme_master_writer.sv
module vme_master_writer
    import vmw_pkg::*;
#(
    parameter  int LEVELS      = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int LVL_W       = $clog2(LEVELS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [1:0]            cfg_sel,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  go,
    input  logic [LO_ADDR_W-1:0]  go_addr,
    input  logic [LO_DATA_W-1:0]  go_data,
    input  logic                  wide,
    input  logic                  blt_en,
    input  logic                  hold_n,
    input  logic [LVL_W-1:0]      br_level,
    output logic                  has_bus,
    output logic                  done,
    output logic [7:0]            irq_vector,
    output logic [LEVELS-1:0]     vme_br_n,
    input  logic [LEVELS-1:0]     vme_bg_in_n,
    output logic [LEVELS-1:0]     vme_bg_out_n,
    output logic                  vme_as_n,
    output logic [1:0]            vme_ds_n,
    input  logic                  vme_dtack_n,
    output logic [31:1]           vme_addr,
    output logic [5:0]            vme_am,
    output logic                  vme_write_n,
    output logic                  vme_lword_n,
    output logic                  vme_addr_oe,
    output logic [BUS_DATA_W-1:0] vme_data,
    output logic                  vme_data_oe_lo,
    output logic                  vme_data_oe_hi
);

    localparam int PAD_W = BUS_DATA_W - LO_DATA_W;

    ctrl_t                ctrl;
    logic [HI_ADDR_W-1:0] hi_addr;
    logic [UP_DATA_W-1:0] up_data;
    logic [LO_ADDR_W-1:0] lo_addr;
    logic [LO_DATA_W-1:0] lo_data;
    logic                 wide_q;
    logic                 req;
    logic                 data_oe;
    logic                 bg_sel_n;
    logic                 bg_sync_n;
    logic                 dtack_sync_n;

    vmw_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .hi_addr   (hi_addr),
        .up_data   (up_data)
    );

    vmw_arb #(.LEVELS(LEVELS)) u_arb (
        .br_level (br_level),
        .req      (req),
        .bg_in_n  (vme_bg_in_n),
        .br_n     (vme_br_n),
        .bg_out_n (vme_bg_out_n),
        .bg_sel_n (bg_sel_n)
    );

    vmw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_bg_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bg_sel_n),
        .q     (bg_sync_n)
    );

    vmw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1), .RST_VAL(1'b1)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (vme_dtack_n),
        .q     (dtack_sync_n)
    );

    vmw_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .go_addr (go_addr),
        .go_data (go_data),
        .wide    (wide),
        .blt_en  (blt_en),
        .hold_n  (hold_n),
        .granted (~bg_sync_n),
        .acked   (~dtack_sync_n),
        .req     (req),
        .has_bus (has_bus),
        .done    (done),
        .as_n    (vme_as_n),
        .ds_n    (vme_ds_n),
        .addr_oe (vme_addr_oe),
        .data_oe (data_oe),
        .lo_addr (lo_addr),
        .lo_data (lo_data),
        .wide_q  (wide_q)
    );

    assign vme_addr       = {hi_addr, lo_addr};
    assign vme_am         = ctrl.am;
    assign vme_write_n    = ctrl.write_lvl;
    assign vme_lword_n    = ctrl.lword_lvl;
    assign irq_vector     = ctrl.vector;
    assign vme_data       = wide_q ? {up_data, lo_data[UP_DATA_W-1:0]}
                                   : {{PAD_W{1'b1}}, lo_data};
    assign vme_data_oe_lo = data_oe;
    assign vme_data_oe_hi = data_oe && wide_q;

endmodule

// File: rtl/vmw_checker.sv
module vmw_checker #(
    parameter  int LEVELS = 4,
    localparam int LVL_W  = $clog2(LEVELS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  br_level,
    input logic              has_bus,
    input logic              done,
    input logic [LEVELS-1:0] vme_br_n,
    input logic [LEVELS-1:0] vme_bg_out_n,
    input logic              vme_as_n,
    input logic [1:0]        vme_ds_n,
    input logic              vme_dtack_n,
    input logic              vme_data_oe_lo,
    input logic              vme_data_oe_hi
);

    p_as_needs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !vme_as_n |-> has_bus);

    p_ds_under_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_ds_n != 2'b11) |-> !vme_as_n);

    p_ds_held_until_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_ds_n == 2'b00 && vme_dtack_n) |=> (vme_ds_n == 2'b00));

    p_br_not_before_as_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vme_br_n == {LEVELS{1'b1}}) |-> vme_as_n);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !has_bus) |-> (vme_br_n == {LEVELS{1'b1}}));

    p_ready_no_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vme_ds_n == 2'b11));

    p_hi_lane_with_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vme_data_oe_hi |-> vme_data_oe_lo);

    p_own_grant_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vme_br_n[br_level] |-> vme_bg_out_n[br_level]);

endmodule

bind vme_master_writer vmw_checker #(.LEVELS(LEVELS)) i_vmw_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .br_level       (br_level),
    .has_bus        (has_bus),
    .done           (done),
    .vme_br_n       (vme_br_n),
    .vme_bg_out_n   (vme_bg_out_n),
    .vme_as_n       (vme_as_n),
    .vme_ds_n       (vme_ds_n),
    .vme_dtack_n    (vme_dtack_n),
    .vme_data_oe_lo (vme_data_oe_lo),
    .vme_data_oe_hi (vme_data_oe_hi)
);

// File: tb/test_vme_master_writer.sv
module test_vme_master_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [23:0] cfg_wdata = '0;
    logic        go = 1'b0;
    logic [14:0] go_addr = '0;
    logic [23:0] go_data = '0;
    logic        wide = 1'b0;
    logic        blt_en = 1'b0;
    logic        hold_n = 1'b1;
    logic [1:0]  br_level = 2'd3;
    logic        has_bus, done;
    logic [7:0]  irq_vector;
    logic [3:0]  vme_br_n, vme_bg_in_n, vme_bg_out_n;
    logic        vme_as_n;
    logic [1:0]  vme_ds_n;
    logic        vme_dtack_n = 1'b1;
    logic [31:1] vme_addr;
    logic [5:0]  vme_am;
    logic        vme_write_n, vme_lword_n, vme_addr_oe;
    logic [31:0] vme_data;
    logic        vme_data_oe_lo, vme_data_oe_hi;

    always #4 clk = ~clk;

    vme_master_writer i_vme_master_writer (.*);

    typedef struct packed {
        logic [31:1] addr;
        logic [31:0] data;
        logic        wide;
        logic        aoe;
        logic [7:0]  ctl;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   pushed = 0;
    int   seen = 0;
    logic [23:0] sh_ctrl = '0;
    logic [15:0] sh_hi = '0;
    logic [15:0] sh_up = '0;
    logic [3:0]  bg_force_n = 4'hF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [23:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 2'd0) sh_ctrl = val;
        if (sel == 2'd1) sh_hi = val[15:0];
        if (sel == 2'd2) sh_up = val[15:0];
    endtask

    task automatic launch(input logic [14:0] a, input logic [23:0] d, input bit aoe);
        exp_t e;
        @(negedge clk);
        while (!done) @(negedge clk);
        e.addr = {sh_hi, a};
        e.data = wide ? {sh_up, d[15:0]} : {8'h00, d};
        e.wide = wide;
        e.aoe  = aoe;
        e.ctl  = sh_ctrl[7:0];
        exp_q.push_back(e);
        pushed++;
        go = 1'b1; go_addr = a; go_data = d;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // arbiter model: grant follows request one half-cycle later
    initial begin
        vme_bg_in_n = 4'hF;
        forever begin
            @(negedge clk);
            vme_bg_in_n = vme_br_n & bg_force_n;
        end
    end

    // slave model
    initial begin
        forever begin
            @(negedge clk);
            if (vme_ds_n == 2'b00) begin
                repeat (2) @(negedge clk);
                vme_dtack_n = 1'b0;
                while (vme_ds_n != 2'b11) @(negedge clk);
                vme_dtack_n = 1'b1;
            end
        end
    end

    // monitor / scoreboard
    initial begin
        logic [1:0] prev_ds;
        exp_t e;
        prev_ds = 2'b11;
        forever begin
            @(negedge clk);
            if (rst_n && vme_ds_n == 2'b00 && prev_ds == 2'b11) begin
                seen++;
                chk(vme_as_n == 1'b0, "R4", "AS low with DS", {31'd0, vme_as_n}, 32'd0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R12", "unexpected bus cycle", {16'd0, vme_addr[16:1]}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    chk(vme_addr_oe == e.aoe, "R10", "address enable",
                        {31'd0, vme_addr_oe}, {31'd0, e.aoe});
                    if (e.aoe) begin
                        chk(vme_addr == e.addr, "R2", "address",
                            {1'b0, vme_addr}, {1'b0, e.addr});
                        chk({vme_lword_n, vme_write_n, vme_am} == e.ctl, "R7", "am/write/lword",
                            {24'd0, vme_lword_n, vme_write_n, vme_am}, {24'd0, e.ctl});
                    end
                    if (e.wide) begin
                        chk(vme_data == e.data, "R5", "32-bit data", vme_data, e.data);
                        chk(vme_data_oe_hi && vme_data_oe_lo, "R5", "both lanes",
                            {30'd0, vme_data_oe_hi, vme_data_oe_lo}, 32'd3);
                    end else begin
                        chk(vme_data[23:0] == e.data[23:0], "R6", "24-bit data",
                            {8'd0, vme_data[23:0]}, e.data);
                        chk(!vme_data_oe_hi && vme_data_oe_lo, "R6", "top byte undriven",
                            {30'd0, vme_data_oe_hi, vme_data_oe_lo}, 32'd1);
                    end
                end
            end
            prev_ds = vme_ds_n;
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done && !has_bus, "R1", "done/has_bus", {30'd0, done, has_bus}, 32'd2);
        chk(vme_br_n == 4'hF && vme_as_n && vme_ds_n == 2'b11, "R1", "bus lines idle",
            {25'd0, vme_br_n, vme_as_n, vme_ds_n}, {25'd0, 4'hF, 1'b1, 2'b11});
        chk(!vme_addr_oe && !vme_data_oe_lo && !vme_data_oe_hi, "R1", "enables",
            {29'd0, vme_addr_oe, vme_data_oe_lo, vme_data_oe_hi}, 32'd0);

        // R7 control word and vector
        cfg_write(2'd0, 24'hA5_0009);
        cfg_write(2'd1, 24'h00_1A00);
        cfg_write(2'd2, 24'h00_BEEF);
        chk(irq_vector == 8'hA5, "R7", "irq vector", {24'd0, irq_vector}, 32'hA5);

        // R3/R5 32-bit write at level 3
        wide = 1'b1;
        launch(15'h0123, 24'h00CAFE, 1'b1);
        chk(vme_br_n == 4'b0111 && !done, "R3", "request level 3",
            {27'd0, vme_br_n, done}, {27'd0, 4'b0111, 1'b0});
        wait_done();
        @(negedge clk);
        chk(vme_br_n == 4'hF && !has_bus && vme_as_n, "R8", "released after cycle",
            {27'd0, vme_br_n, has_bus}, {27'd0, 4'hF, 1'b0});

        // R2/R6 24-bit write, high address not rewritten
        wide = 1'b0;
        launch(15'h0456, 24'h123456, 1'b1);
        wait_done();

        // R3 level 1, new control word
        br_level = 2'd1;
        cfg_write(2'd0, 24'h3C_00F9);
        launch(15'h7FFF, 24'hABCDEF, 1'b1);
        chk(vme_br_n == 4'b1101, "R3", "request level 1", {28'd0, vme_br_n}, {28'd0, 4'b1101});
        wait_done();

        // R12 go while busy ignored
        wide = 1'b1;
        launch(15'h0010, 24'h001111, 1'b1);
        while (vme_ds_n != 2'b00) @(negedge clk);
        go = 1'b1; go_addr = 15'h0555; go_data = 24'h999999;
        @(negedge clk);
        go = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(seen == pushed, "R12", "bus cycle count", seen, pushed);

        // R9 hold the bus
        br_level = 2'd2;
        hold_n = 1'b0;
        while (!has_bus) @(negedge clk);
        chk(vme_br_n == 4'b1011 && vme_as_n, "R9", "held without cycle",
            {27'd0, vme_br_n, vme_as_n}, {27'd0, 4'b1011, 1'b1});
        // R11 daisy chain while requesting
        bg_force_n = 4'b1110;
        @(negedge clk); @(negedge clk);
        chk(vme_bg_out_n == 4'b1110, "R11", "own lane blocked", {28'd0, vme_bg_out_n}, 32'hE);
        bg_force_n = 4'hF;
        launch(15'h0200, 24'h00AAAA, 1'b1);
        wait_done();
        chk(has_bus && vme_br_n == 4'b1011 && vme_as_n, "R9", "bus kept between transfers",
            {27'd0, vme_br_n, has_bus}, {27'd0, 4'b1011, 1'b1});

        // R10 block transfer inside held bus
        blt_en = 1'b1;
        launch(15'h0300, 24'h000001, 1'b1);
        wait_done();
        chk(!vme_as_n, "R10", "AS held between beats", {31'd0, vme_as_n}, 32'd0);
        launch(15'h0301, 24'h000002, 1'b0);
        wait_done();
        launch(15'h0302, 24'h000003, 1'b0);
        wait_done();
        blt_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(vme_as_n && has_bus, "R10", "block ended into held bus",
            {30'd0, vme_as_n, has_bus}, 32'd3);
        hold_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(vme_br_n == 4'hF && !has_bus, "R9", "release on hold high",
            {27'd0, vme_br_n, has_bus}, {27'd0, 4'hF, 1'b0});

        // R10 block transfer from idle
        blt_en = 1'b1;
        launch(15'h0400, 24'h000004, 1'b1);
        wait_done();
        launch(15'h0401, 24'h000005, 1'b0);
        wait_done();
        blt_en = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(vme_as_n && vme_br_n == 4'hF, "R10", "block end releases bus",
            {27'd0, vme_br_n, vme_as_n}, {27'd0, 4'hF, 1'b1});

        // R11 daisy chain when idle
        bg_force_n = 4'b1010;
        @(negedge clk); @(negedge clk);
        chk(vme_bg_out_n == 4'b1010, "R11", "pass-through idle", {28'd0, vme_bg_out_n}, 32'hA);
        bg_force_n = 4'hF;

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0 && seen == pushed, "R12", "scoreboard drained",
            seen, pushed);
        report();
    end

endmodule